// File: doc/BRIEF.md
# Credit-Limited Thread-Block Dispatcher

This block places thread blocks from several client subcontexts onto a pool of processing clusters (TPCs). Every cycle, each client can present one pending block together with a per-kernel TPC enable mask. The block picks one client by round-robin arbitration. For that client it picks the least-occupied TPC that the client is allowed to use, and reports the placement on the same cycle as a ready/dispatch handshake. A completion port reports a finished block, naming its client and its TPC, and that frees a slot.

Each TPC is modelled only as a count of resident blocks per client, with a fixed capacity. Each client also holds a programmable credit count, which limits how many distinct TPCs it may hold at once. A client spends a credit when it first lands on a TPC. It gets the credit back when its last block there finishes. Credits say nothing about which TPCs a client gets, so two clients can crowd onto the same clusters while others stay idle.

An enable input turns credit enforcement on and off. With enforcement off, placement falls back to the mask, capacity and least-occupied rules alone.

Top module: `credit_dispatch`

## Requirements
- R1: With `part_en` high, a dispatch to a TPC on which the client has no resident block lowers that client's credit count by one.
- R2: With `part_en` high, a client whose credit count is zero is dispatched only to TPCs where it already has a resident block.
- R3: With `part_en` high, when a completion removes a client's last block from a TPC, that client's credit count rises by one, saturating at its maximum. A dispatch of the same client to the same TPC in the same cycle cancels this.
- R4: Among the eligible TPCs, the block goes to the one with the fewest resident blocks from all clients. Ties go to the lowest TPC index.
- R5: A block is never placed on TPC t of client c when bit `c*NTPC+t` of `req_mask` is clear.
- R6: A TPC holding `CAP` blocks is ineligible, so no TPC ever holds more than `CAP` blocks.
- R7: When a valid client has no eligible TPC, its `req_ready` stays low and the request remains pending. Eligibility uses the state at the start of the cycle, so a completion helps only from the next cycle on.
- R8: Among clients that are valid and have an eligible TPC, the grant goes to the first one found searching upward (with wrap-around) from a pointer. After each dispatch, the pointer moves to one past the granted client.
- R9: With `part_en` low, credits are neither checked nor changed.
- R10: A cycle with `cfg_we` high sets the credit count of client `cfg_cli` to `cfg_credits`, overriding any spend or refund for that client in the same cycle.
- R11: After reset, every TPC is empty, every client holds `INIT_CRED` credits and the round-robin pointer is at client 0.
- R12: A completion naming a client with no resident block on the named TPC has no effect.
- R13: `disp_valid` is high exactly when one bit of `req_ready` is high, with `disp_cli` and `disp_tpc` naming that client and its chosen TPC in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| part_en | input | 1 | Credit enforcement enable |
| cfg_we | input | 1 | Credit write strobe |
| cfg_cli | input | CW | Client whose credits are written |
| cfg_credits | input | CRW | New credit count |
| req_valid | input | NCLI | Per-client block pending |
| req_mask | input | NCLI*NTPC | Per-client TPC enable mask, bit c*NTPC+t |
| req_ready | output | NCLI | Per-client block accepted this cycle |
| disp_valid | output | 1 | A block is dispatched this cycle |
| disp_cli | output | CW | Client of the dispatched block |
| disp_tpc | output | TW | TPC receiving the block |
| done_valid | input | 1 | A block finished |
| done_cli | input | CW | Client of the finished block |
| done_tpc | input | TW | TPC the finished block leaves |

## Verification
The placement rule is driven with several patterns: one client filling the pool until its credits run out, a client whose credits reach zero while its TPCs still have room, and a client that fills both of its TPCs and stalls. Further patterns cover masks that allow one TPC or a pair, and two clients competing in alternating cycles. Each pattern isolates one decision. A credit spent versus not spent shows up as a stall or a new TPC. A tie shows as the lower index winning. A full TPC shows as a skip or a stall. The round-robin pointer shows as which client wins. Directed cases then toggle the enable, rewrite credits, and send completions for blocks that are not resident. In each case, a later dispatch reveals whether the hidden credit or occupancy state moved.

// File: rtl/cd_pkg.sv
// Shared defaults for the credit-limited dispatcher.
// Assumes at least two clients and two TPCs so index widths are non-zero.
package cd_pkg;
    parameter int unsigned CD_NCLI      = 4;
    parameter int unsigned CD_NTPC      = 8;
    parameter int unsigned CD_CAP       = 2;
    parameter int unsigned CD_CRW       = 4;
    parameter int unsigned CD_INIT_CRED = 2;
endpackage

// File: rtl/cd_rr_arb.sv
// Round-robin arbiter: grants the first requester at or above the pointer,
// wrapping around. Assumes N >= 2; the pointer advances only on adv.
module cd_rr_arb #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          hit
);
    logic [IW-1:0] ptr_q;

    // Search upward from the pointer for the first request.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        hit     = 1'b0;
        for (int off = 0; off < int'(N); off++) begin
            int k;
            k = (int'(ptr_q) + off) % int'(N);
            if (!hit && req[k]) begin
                hit     = 1'b1;
                gnt_idx = IW'(k);
                gnt[k]  = 1'b1;
            end
        end
    end

    // Move the pointer one past the winner after a dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv)
            ptr_q <= (int'(gnt_idx) == int'(N) - 1) ? '0 : gnt_idx + IW'(1);
    end
endmodule

// File: rtl/cd_pick.sv
// Least-occupied picker: among eligible TPCs picks the lowest load,
// lowest index on a tie. Purely combinational.
module cd_pick #(
    parameter int unsigned NTPC = 8,
    parameter int unsigned OW   = 2,
    localparam int unsigned TW  = $clog2(NTPC)
) (
    input  logic [NTPC-1:0]    elig,
    input  logic [NTPC*OW-1:0] load_flat,
    output logic               found,
    output logic [TW-1:0]      idx
);
    logic [OW-1:0] best;

    // Strict less-than keeps the earliest index on equal loads.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int t = 0; t < int'(NTPC); t++) begin
            if (elig[t] && (!found || load_flat[t*OW +: OW] < best)) begin
                found = 1'b1;
                idx   = TW'(t);
                best  = load_flat[t*OW +: OW];
            end
        end
    end
endmodule

// File: rtl/cd_track.sv
// Occupancy and credit state: per-(TPC,client) block counts, per-TPC load
// and per-client credits. Assumes dispatches never exceed capacity and
// only spend credits that exist (the eligibility logic guarantees both).
module cd_track #(
    parameter int unsigned NCLI      = 4,
    parameter int unsigned NTPC      = 8,
    parameter int unsigned CAP       = 2,
    parameter int unsigned CRW       = 4,
    parameter int unsigned INIT_CRED = 2,
    localparam int unsigned OW = $clog2(CAP + 1),
    localparam int unsigned TW = $clog2(NTPC),
    localparam int unsigned CW = $clog2(NCLI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 part_en,
    input  logic                 disp_valid,
    input  logic [CW-1:0]        disp_cli,
    input  logic [TW-1:0]        disp_tpc,
    input  logic                 done_valid,
    input  logic [CW-1:0]        done_cli,
    input  logic [TW-1:0]        done_tpc,
    input  logic                 cfg_we,
    input  logic [CW-1:0]        cfg_cli,
    input  logic [CRW-1:0]       cfg_credits,
    output logic [NTPC*OW-1:0]   load_flat,
    output logic [NTPC*NCLI-1:0] occ_nz,
    output logic [NCLI*CRW-1:0]  cred_flat
);
    logic [OW-1:0]  occ_q  [NTPC][NCLI];
    logic [OW-1:0]  occ_d  [NTPC][NCLI];
    logic [OW-1:0]  load_q [NTPC];
    logic [OW-1:0]  load_d [NTPC];
    logic [CRW-1:0] cred_q [NCLI];
    logic [CRW-1:0] cred_d [NCLI];
    logic           done_hit, spend, refund, same_slot;

    assign done_hit  = done_valid && (occ_q[done_tpc][done_cli] != '0);
    assign same_slot = disp_valid && (disp_cli == done_cli) && (disp_tpc == done_tpc);
    assign spend     = disp_valid && part_en && (occ_q[disp_tpc][disp_cli] == '0);
    assign refund    = done_hit && part_en && (occ_q[done_tpc][done_cli] == OW'(1)) && !same_slot;

    // Next-state: add dispatch, remove completion, then adjust credits.
    always_comb begin
        occ_d  = occ_q;
        load_d = load_q;
        cred_d = cred_q;
        if (disp_valid) begin
            occ_d[disp_tpc][disp_cli] = occ_d[disp_tpc][disp_cli] + OW'(1);
            load_d[disp_tpc]          = load_d[disp_tpc] + OW'(1);
        end
        if (done_hit) begin
            occ_d[done_tpc][done_cli] = occ_d[done_tpc][done_cli] - OW'(1);
            load_d[done_tpc]          = load_d[done_tpc] - OW'(1);
        end
        if (spend)
            cred_d[disp_cli] = cred_d[disp_cli] - CRW'(1);
        if (refund && (cred_d[done_cli] != '1))
            cred_d[done_cli] = cred_d[done_cli] + CRW'(1);
        if (cfg_we)
            cred_d[cfg_cli] = cfg_credits;
    end

    // State registers with reset to empty pool and initial credits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < int'(NTPC); t++) begin
                load_q[t] <= '0;
                for (int c = 0; c < int'(NCLI); c++) occ_q[t][c] <= '0;
            end
            for (int c = 0; c < int'(NCLI); c++) cred_q[c] <= CRW'(INIT_CRED);
        end else begin
            occ_q  <= occ_d;
            load_q <= load_d;
            cred_q <= cred_d;
        end
    end

    for (genvar t = 0; t < NTPC; t++) begin : g_tpc
        assign load_flat[t*OW +: OW] = load_q[t];
        for (genvar c = 0; c < NCLI; c++) begin : g_cli
            assign occ_nz[t*NCLI + c] = (occ_q[t][c] != '0);
        end
    end
    for (genvar c = 0; c < NCLI; c++) begin : g_cred
        assign cred_flat[c*CRW +: CRW] = cred_q[c];
    end
endmodule

// File: rtl/credit_dispatch.sv
// Top: computes per-client TPC eligibility (mask, capacity, credits),
// arbitrates clients round-robin and places the winner's block on the
// least-occupied eligible TPC. Handshake and placement are same-cycle.
module credit_dispatch #(
    parameter int unsigned NCLI      = cd_pkg::CD_NCLI,
    parameter int unsigned NTPC      = cd_pkg::CD_NTPC,
    parameter int unsigned CAP       = cd_pkg::CD_CAP,
    parameter int unsigned CRW       = cd_pkg::CD_CRW,
    parameter int unsigned INIT_CRED = cd_pkg::CD_INIT_CRED,
    localparam int unsigned OW = $clog2(CAP + 1),
    localparam int unsigned TW = $clog2(NTPC),
    localparam int unsigned CW = $clog2(NCLI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 part_en,
    input  logic                 cfg_we,
    input  logic [CW-1:0]        cfg_cli,
    input  logic [CRW-1:0]       cfg_credits,
    input  logic [NCLI-1:0]      req_valid,
    input  logic [NCLI*NTPC-1:0] req_mask,
    output logic [NCLI-1:0]      req_ready,
    output logic                 disp_valid,
    output logic [CW-1:0]        disp_cli,
    output logic [TW-1:0]        disp_tpc,
    input  logic                 done_valid,
    input  logic [CW-1:0]        done_cli,
    input  logic [TW-1:0]        done_tpc
);
    logic [NTPC*OW-1:0]   load_flat;
    logic [NTPC*NCLI-1:0] occ_nz;
    logic [NCLI*CRW-1:0]  cred_flat;
    logic [NCLI*NTPC-1:0] elig_flat;
    logic [NCLI-1:0]      arb_req, gnt;
    logic [CW-1:0]        gnt_idx;
    logic                 arb_hit, pick_found;
    logic [TW-1:0]        pick_idx;

    // Eligibility of every (client, TPC) pair from the current state.
    for (genvar c = 0; c < NCLI; c++) begin : g_el_c
        for (genvar t = 0; t < NTPC; t++) begin : g_el_t
            assign elig_flat[c*NTPC + t] = req_mask[c*NTPC + t]
                && (load_flat[t*OW +: OW] < OW'(CAP))
                && (!part_en || occ_nz[t*NCLI + c] || (cred_flat[c*CRW +: CRW] != '0));
        end
        assign arb_req[c] = req_valid[c] && (|elig_flat[c*NTPC +: NTPC]);
    end

    cd_rr_arb #(.N(NCLI)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(arb_req), .adv(disp_valid),
        .gnt(gnt), .gnt_idx(gnt_idx), .hit(arb_hit)
    );

    cd_pick #(.NTPC(NTPC), .OW(OW)) u_pick (
        .elig(elig_flat[gnt_idx*NTPC +: NTPC]), .load_flat(load_flat),
        .found(pick_found), .idx(pick_idx)
    );

    assign disp_valid = arb_hit && pick_found;
    assign req_ready  = disp_valid ? gnt : '0;
    assign disp_cli   = gnt_idx;
    assign disp_tpc   = pick_idx;

    cd_track #(.NCLI(NCLI), .NTPC(NTPC), .CAP(CAP), .CRW(CRW), .INIT_CRED(INIT_CRED)) u_track (
        .clk(clk), .rst_n(rst_n), .part_en(part_en),
        .disp_valid(disp_valid), .disp_cli(disp_cli), .disp_tpc(disp_tpc),
        .done_valid(done_valid), .done_cli(done_cli), .done_tpc(done_tpc),
        .cfg_we(cfg_we), .cfg_cli(cfg_cli), .cfg_credits(cfg_credits),
        .load_flat(load_flat), .occ_nz(occ_nz), .cred_flat(cred_flat)
    );
endmodule

// File: rtl/credit_dispatch_chk.sv
// Checker bound to credit_dispatch: relates handshake outputs to the
// mask input and to the state held by the tracker.
module credit_dispatch_chk #(
    parameter int unsigned NCLI = 4,
    parameter int unsigned NTPC = 8,
    parameter int unsigned CAP  = 2,
    parameter int unsigned CRW  = 4,
    localparam int unsigned OW = $clog2(CAP + 1),
    localparam int unsigned TW = $clog2(NTPC),
    localparam int unsigned CW = $clog2(NCLI)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 part_en,
    input logic [NCLI-1:0]      req_valid,
    input logic [NCLI*NTPC-1:0] req_mask,
    input logic [NCLI-1:0]      req_ready,
    input logic                 disp_valid,
    input logic [CW-1:0]        disp_cli,
    input logic [TW-1:0]        disp_tpc,
    input logic [NTPC*OW-1:0]   load_flat,
    input logic [NTPC*NCLI-1:0] occ_nz,
    input logic [NCLI*CRW-1:0]  cred_flat
);
    assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> req_mask[int'(disp_cli)*NTPC + int'(disp_tpc)]);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (load_flat[int'(disp_tpc)*OW +: OW] < OW'(CAP)));

    assert_zero_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && part_en && (cred_flat[int'(disp_cli)*CRW +: CRW] == '0))
        |-> occ_nz[int'(disp_tpc)*NCLI + int'(disp_cli)]);

    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    assert_ready_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    assert_disp_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid == ($countones(req_ready) == 1));

    for (genvar t = 0; t < NTPC; t++) begin : g_ld
        assert_load_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            load_flat[t*OW +: OW] <= OW'(CAP));
    end
endmodule

bind credit_dispatch credit_dispatch_chk #(.NCLI(NCLI), .NTPC(NTPC), .CAP(CAP), .CRW(CRW)) u_chk (.*);

// File: tb/sim_credit_dispatch.sv
// Bench: a vector table walked in order, then directed cases.
module sim_credit_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        part_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_cli = '0;
    logic [3:0]  cfg_credits = '0;
    logic [3:0]  req_valid = '0;
    logic [31:0] req_mask = '0;
    logic [3:0]  req_ready;
    logic        disp_valid;
    logic [1:0]  disp_cli;
    logic [2:0]  disp_tpc;
    logic        done_valid = 1'b0;
    logic [1:0]  done_cli = '0;
    logic [2:0]  done_tpc = '0;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    credit_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .part_en(part_en), .cfg_we(cfg_we),
        .cfg_cli(cfg_cli), .cfg_credits(cfg_credits), .req_valid(req_valid),
        .req_mask(req_mask), .req_ready(req_ready), .disp_valid(disp_valid),
        .disp_cli(disp_cli), .disp_tpc(disp_tpc), .done_valid(done_valid),
        .done_cli(done_cli), .done_tpc(done_tpc)
    );

    // Entry: done_valid, done_cli, done_tpc, req_valid, mask (all clients), exp_ready, exp_tpc
    localparam logic [24:0] TBL [15] = '{
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd0},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd1},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd0},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd1},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0000, 3'd0},
        {1'b1, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0000, 3'd0},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd0},
        {1'b1, 2'd0, 3'd1, 4'b0000, 8'hFF, 4'b0000, 3'd0},
        {1'b1, 2'd0, 3'd1, 4'b0000, 8'hFF, 4'b0000, 3'd0},
        {1'b0, 2'd0, 3'd0, 4'b0001, 8'hFF, 4'b0001, 3'd1},
        {1'b0, 2'd0, 3'd0, 4'b0010, 8'h80, 4'b0010, 3'd7},
        {1'b0, 2'd0, 3'd0, 4'b0010, 8'h06, 4'b0010, 3'd2},
        {1'b0, 2'd0, 3'd0, 4'b0110, 8'hFF, 4'b0100, 3'd3},
        {1'b0, 2'd0, 3'd0, 4'b0110, 8'hFF, 4'b0010, 3'd2},
        {1'b0, 2'd0, 3'd0, 4'b0110, 8'hFF, 4'b0100, 3'd4}
    };
    // R11/R4 first spread, R1 spend, R2 zero credit, R6 full, R7 stall,
    // R3 refund, R5 mask, R8 round-robin.
    localparam string TAG [15] = '{
        "R11", "R1", "R2", "R6", "R7", "R7", "R7", "R12", "R3",
        "R3", "R5", "R4", "R8", "R8", "R8"
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check the handshake at the current cycle, then move to the next negedge.
    task automatic expect_cycle(input logic [3:0] er, input logic [2:0] et, input string req);
        #1;
        chk(req_ready == er, req, int'(req_ready), int'(er));
        chk(disp_valid == (er != 0), "R13", int'(disp_valid), int'(er != 0));
        if (er != 0) chk(disp_tpc == et, req, int'(disp_tpc), int'(et));
        @(negedge clk);
        done_valid = 1'b0;
        cfg_we = 1'b0;
        req_valid = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: empty after reset, nothing dispatched
        #1 chk(req_ready == 4'b0 && !disp_valid, "R11", int'(req_ready), 0);
        @(negedge clk);
        // R5: all masks clear, all clients valid -> nothing accepted
        req_valid = 4'b1111; req_mask = '0;
        expect_cycle(4'b0000, 3'd0, "R5");

        for (int i = 0; i < 15; i++) begin
            done_valid = TBL[i][24];
            done_cli   = TBL[i][23:22];
            done_tpc   = TBL[i][21:19];
            req_valid  = TBL[i][18:15];
            req_mask   = {4{TBL[i][14:7]}};
            expect_cycle(TBL[i][6:3], TBL[i][2:0], TAG[i]);
        end

        // R9: enforcement off, client2 with zero credits reaches a fresh TPC
        part_en = 1'b0; req_valid = 4'b0100; req_mask = {4{8'hFF}};
        expect_cycle(4'b0100, 3'd5, "R9");
        // R9: re-enabled, credits were not touched (still zero) -> stall on new TPC6
        part_en = 1'b1; req_valid = 4'b0100; req_mask = 32'h0040_0000;
        expect_cycle(4'b0000, 3'd0, "R9");
        // R10: write one credit, then TPC6 becomes reachable
        cfg_we = 1'b1; cfg_cli = 2'd2; cfg_credits = 4'd1;
        expect_cycle(4'b0000, 3'd0, "R10");
        req_valid = 4'b0100; req_mask = 32'h0040_0000;
        expect_cycle(4'b0100, 3'd6, "R10");
        // R12: completion for non-resident client3 on TPC0 leaves TPC0 full
        done_valid = 1'b1; done_cli = 2'd3; done_tpc = 3'd0;
        expect_cycle(4'b0000, 3'd0, "R12");
        req_valid = 4'b0001; req_mask = 32'h0000_0001;
        expect_cycle(4'b0000, 3'd0, "R12");
        // R6/R7: real completion on TPC0 frees a slot for the next cycle
        done_valid = 1'b1; done_cli = 2'd0; done_tpc = 3'd0;
        expect_cycle(4'b0000, 3'd0, "R7");
        req_valid = 4'b0001; req_mask = 32'h0000_0001;
        expect_cycle(4'b0001, 3'd0, "R6");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule